// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache

This unit is the read-lookup path of a direct-mapped cache. It takes a request made of a virtual byte address and an address-space identifier. The set is chosen from the untranslated low bits of the address. In the same cycle, an 8-entry fully associative translation buffer maps the virtual page number to a physical page number. Each set stores a physical page number as its tag. A hit is declared only when that stored tag equals the page number that comes out of the translation buffer. Translation therefore runs beside the array read and is not in series with it.

When no translation exists for the pair of address space and virtual page, the unit flags a translation miss and stalls. It waits for software or a walker to install an entry through the translation fill port, and then runs the stored lookup again. When translation succeeds but the line is absent, the unit asks for the physical line. It waits for a whole line on the line fill port, writes the line and delivers the word. Cache lines carry no address-space identifier. A change of process therefore leaves cached data usable.

Top module: `vipt_cache`

## Requirements
- R1: The set index is vaddr[11:4], which lies inside the 4 KiB page offset. The stored tag is the 20-bit physical page number. A line loaded through one virtual page hits when it is reached through another virtual page that translates to the same physical page at the same offset.
- R2: When the translation and the line are both present, the response arrives in the cycle after the request is accepted. It has resp_valid=1, resp_hit=1 and resp_miss=0. resp_data is the 32-bit word selected by vaddr[3:2], where word w occupies line bits [32w+31:32w].
- R3: On a translation miss, xlat_miss and busy are 1 from the cycle after acceptance. No response is given until a translation fill arrives. The stored request is then looked up again. Its final response has resp_tlb_miss=1. A request that translates on its first try reports resp_tlb_miss=0.
- R4: A translation entry matches only when both its address-space ID and its virtual page number equal the request's values.
- R5: A change of address-space ID invalidates no cache line. The same physical line reached from a new address space returns resp_hit=1.
- R6: A line miss after a successful translation raises miss_req_valid from the cycle after the lookup. miss_req_paddr is {ppn, vaddr[11:4], 4'h0}, and both stay unchanged until fill_valid.
- R7: A line fill writes the line, the physical tag and the valid bit. In the next cycle it gives resp_valid=1, resp_miss=1, resp_hit=0 and the selected word of the filled line. A later access to that line hits.
- R8: Translation fills replace the 8 entries in round-robin order, starting at entry 0 after reset. The ninth fill evicts the first.
- R9: While busy is 1, req_valid is ignored: it produces no response and leaves the pending miss request unchanged.
- R10: Reset clears every cache and translation valid bit. While reset is active and after it, the outputs busy, xlat_miss, miss_req_valid and resp_valid are 0. The first access after reset misses in translation and then in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request, accepted when busy is 0 |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_asid | input | 8 | Address-space ID of the request |
| busy | output | 1 | A request is pending and new requests are ignored |
| tlb_fill_valid | input | 1 | Install a translation |
| tlb_fill_asid | input | 8 | Address-space ID of the installed translation |
| tlb_fill_vpn | input | 20 | Virtual page number of the installed translation |
| tlb_fill_ppn | input | 20 | Physical page number of the installed translation |
| xlat_miss | output | 1 | Waiting for a translation fill |
| miss_req_valid | output | 1 | Waiting for a line fill |
| miss_req_paddr | output | 32 | Physical line address of the pending line miss |
| fill_valid | input | 1 | Line fill data is present |
| fill_data | input | 128 | Whole line, word 0 in the low bits |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Data served from the array on lookup |
| resp_miss | output | 1 | Data served after a line fill |
| resp_tlb_miss | output | 1 | The request needed a translation fill |
| resp_data | output | 32 | Selected word |

## Verification
The assertions assume that the translation buffer never holds two valid entries for the same pair of address space and virtual page. They also assume that line fills arrive only while a line miss is outstanding. The bench keeps both assumptions by installing a translation only after the unit has reported a miss for that exact pair. It drives fill_valid only in the cycle it picks after miss_req_valid is seen. Translations come from a fixed mapping function. Some pairs in different address spaces map to the same physical page on purpose, so that synonym hits across address spaces occur.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int DEF_VA_W       = 32;
  localparam int DEF_PA_W       = 32;
  localparam int DEF_PAGE_OFF_W = 12;
  localparam int DEF_LINE_OFF_W = 4;
  localparam int DEF_SETS       = 256;
  localparam int DEF_ASID_W     = 8;
  localparam int DEF_TLB_ENT    = 8;
  localparam int DEF_WORD_W     = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XLAT   = 2'd1,
    ST_REPLAY = 2'd2,
    ST_LINE   = 2'd3
  } lookup_state_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int ENTRIES = vipt_pkg::DEF_TLB_ENT,
  parameter int ASID_W  = vipt_pkg::DEF_ASID_W,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] match;
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = ent_v[e] && (ent_asid[e] == lk_asid) && (ent_vpn[e] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) lk_ppn = lk_ppn | ent_ppn[e];
    end
  end
  assign lk_hit = |match;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en) ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ent_v <= '0;
    end else if (fill_en) begin
      ptr_q        <= ptr_d;
      ent_v[ptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_asid[ptr_q] <= fill_asid;
      ent_vpn[ptr_q]  <= fill_vpn;
      ent_ppn[ptr_q]  <= fill_ppn;
    end
  end

  // R4: at most one entry may claim a given address space and page
  assert_tlb_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3: an installed translation is visible to the lookup in the next cycle
  assert_fill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ((lk_asid != $past(fill_asid)) || (lk_vpn != $past(fill_vpn)) ||
                 (lk_hit && (lk_ppn == $past(fill_ppn)))));
endmodule

// File: rtl/vipt_array.sv
module vipt_array #(
  parameter int SETS   = vipt_pkg::DEF_SETS,
  parameter int PPN_W  = 20,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [PPN_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PPN_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [SETS-1:0]   valid_q;
  logic [PPN_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_line  = line_mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q         <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  // R7: a filled set reads back valid with the new tag and line
  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_idx != $past(wr_idx)) ||
               (rd_valid && (rd_tag == $past(wr_tag)) && (rd_line == $past(wr_line)))));
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int VA_W       = DEF_VA_W,
  parameter int PA_W       = DEF_PA_W,
  parameter int PAGE_OFF_W = DEF_PAGE_OFF_W,
  parameter int LINE_OFF_W = DEF_LINE_OFF_W,
  parameter int SETS       = DEF_SETS,
  parameter int ASID_W     = DEF_ASID_W,
  parameter int WORD_W     = DEF_WORD_W,
  localparam int PPN_W     = PA_W - PAGE_OFF_W,
  localparam int IDX_W     = $clog2(SETS),
  localparam int LINE_W    = 8 * (2 ** LINE_OFF_W),
  localparam int BOFF_W    = $clog2(WORD_W / 8),
  localparam int WSEL_W    = LINE_OFF_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  output logic [VA_W-1:0]   lk_vaddr,
  output logic [ASID_W-1:0] lk_asid,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic              tlb_fill_valid,
  input  logic              arr_valid,
  input  logic [PPN_W-1:0]  arr_tag,
  input  logic [LINE_W-1:0] arr_line,
  output logic              arr_wr_en,
  output logic [IDX_W-1:0]  arr_wr_idx,
  output logic [PPN_W-1:0]  arr_wr_tag,
  output logic [LINE_W-1:0] arr_wr_line,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data,
  output logic              busy,
  output logic              xlat_miss,
  output logic              miss_req_valid,
  output logic [PA_W-1:0]   miss_req_paddr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_tlb_miss,
  output logic [WORD_W-1:0] resp_data
);
  lookup_state_t state_q, state_d;
  logic [VA_W-1:0]   pv_q, pv_d;
  logic [ASID_W-1:0] pa_q, pa_d;
  logic [PPN_W-1:0]  pp_q, pp_d;
  logic              pt_q, pt_d;
  logic              rv_d, rh_d, rm_d, rt_d;
  logic [WORD_W-1:0] rdat_d;
  logic              lookup_go, replaying, line_hit;
  logic [WSEL_W-1:0] lk_wsel, pv_wsel;
  logic [WORD_W-1:0] arr_word, fill_word;
  logic              unused_byte_bits;

  // the lookup runs on the live request when idle, on the stored one when replaying
  assign replaying = (state_q == ST_REPLAY);
  assign lk_vaddr  = (state_q == ST_IDLE) ? req_vaddr : pv_q;
  assign lk_asid   = (state_q == ST_IDLE) ? req_asid  : pa_q;
  assign lookup_go = ((state_q == ST_IDLE) && req_valid) || replaying;
  assign line_hit  = tlb_hit && arr_valid && (arr_tag == tlb_ppn);

  assign lk_wsel   = lk_vaddr[LINE_OFF_W-1:BOFF_W];
  assign pv_wsel   = pv_q[LINE_OFF_W-1:BOFF_W];
  assign arr_word  = arr_line[lk_wsel*WORD_W +: WORD_W];
  assign fill_word = fill_data[pv_wsel*WORD_W +: WORD_W];
  assign unused_byte_bits = ^lk_vaddr[BOFF_W-1:0];

  assign arr_wr_idx  = pv_q[LINE_OFF_W +: IDX_W];
  assign arr_wr_tag  = pp_q;
  assign arr_wr_line = fill_data;

  assign busy           = (state_q != ST_IDLE);
  assign xlat_miss      = (state_q == ST_XLAT);
  assign miss_req_valid = (state_q == ST_LINE);
  assign miss_req_paddr = {pp_q, pv_q[PAGE_OFF_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};

  always_comb begin
    state_d   = state_q;
    pv_d      = pv_q;
    pa_d      = pa_q;
    pp_d      = pp_q;
    pt_d      = pt_q;
    rv_d      = 1'b0;
    rh_d      = 1'b0;
    rm_d      = 1'b0;
    rt_d      = 1'b0;
    rdat_d    = resp_data;
    arr_wr_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          pv_d = req_vaddr;
          pa_d = req_asid;
          pt_d = 1'b0;
        end
      end
      ST_XLAT: begin
        if (tlb_fill_valid) state_d = ST_REPLAY;
      end
      ST_LINE: begin
        if (fill_valid) begin
          arr_wr_en = 1'b1;
          rv_d      = 1'b1;
          rm_d      = 1'b1;
          rt_d      = pt_q;
          rdat_d    = fill_word;
          state_d   = ST_IDLE;
        end
      end
      default: ;
    endcase
    if (lookup_go) begin
      if (!tlb_hit) begin
        state_d = ST_XLAT;
        pt_d    = 1'b1;
      end else if (line_hit) begin
        state_d = ST_IDLE;
        rv_d    = 1'b1;
        rh_d    = 1'b1;
        rt_d    = replaying;
        rdat_d  = arr_word;
      end else begin
        state_d = ST_LINE;
        pp_d    = tlb_ppn;
        pt_d    = replaying;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      pt_q          <= 1'b0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_miss     <= 1'b0;
      resp_tlb_miss <= 1'b0;
    end else begin
      state_q       <= state_d;
      pt_q          <= pt_d;
      resp_valid    <= rv_d;
      resp_hit      <= rh_d;
      resp_miss     <= rm_d;
      resp_tlb_miss <= rt_d;
    end
  end

  always_ff @(posedge clk) begin
    pv_q      <= pv_d;
    pa_q      <= pa_d;
    pp_q      <= pp_d;
    resp_data <= rdat_d;
  end

  // R2: every response is exactly one of array hit or filled miss
  assert_resp_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit != resp_miss));

  // R3: without a translation fill the stall holds and no response leaks out
  assert_xlat_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_miss && !tlb_fill_valid) |=> (xlat_miss && !resp_valid));

  // R6: the miss request and its address hold until the line arrives
  assert_missreq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req_valid && !fill_valid) |=> (miss_req_valid && $stable(miss_req_paddr)));

  // R7: a line fill completes the access in the next cycle
  assert_fill_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req_valid && fill_valid) |=> (resp_valid && resp_miss && !busy));

  // R9: a request during a line wait leaves the wait unchanged
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req_valid && req_valid && !fill_valid) |=> (miss_req_valid && !resp_valid));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W        = vipt_pkg::DEF_VA_W,
  parameter int PA_W        = vipt_pkg::DEF_PA_W,
  parameter int PAGE_OFF_W  = vipt_pkg::DEF_PAGE_OFF_W,
  parameter int LINE_OFF_W  = vipt_pkg::DEF_LINE_OFF_W,
  parameter int SETS        = vipt_pkg::DEF_SETS,
  parameter int ASID_W      = vipt_pkg::DEF_ASID_W,
  parameter int TLB_ENTRIES = vipt_pkg::DEF_TLB_ENT,
  parameter int WORD_W      = vipt_pkg::DEF_WORD_W,
  localparam int VPN_W      = VA_W - PAGE_OFF_W,
  localparam int PPN_W      = PA_W - PAGE_OFF_W,
  localparam int IDX_W      = $clog2(SETS),
  localparam int LINE_W     = 8 * (2 ** LINE_OFF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  output logic              busy,
  input  logic              tlb_fill_valid,
  input  logic [ASID_W-1:0] tlb_fill_asid,
  input  logic [VPN_W-1:0]  tlb_fill_vpn,
  input  logic [PPN_W-1:0]  tlb_fill_ppn,
  output logic              xlat_miss,
  output logic              miss_req_valid,
  output logic [PA_W-1:0]   miss_req_paddr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_tlb_miss,
  output logic [WORD_W-1:0] resp_data
);
  // the set must be chosen from bits translation leaves untouched
  generate
    if (IDX_W + LINE_OFF_W > PAGE_OFF_W) begin : g_synonym_guard
      $error("set index and line offset reach above the page offset");
    end
  endgenerate

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic [VA_W-1:0]   lk_vaddr;
  logic [ASID_W-1:0] lk_asid;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;
  logic              arr_valid;
  logic [PPN_W-1:0]  arr_tag;
  logic [LINE_W-1:0] arr_line;
  logic              arr_wr_en;
  logic [IDX_W-1:0]  arr_wr_idx;
  logic [PPN_W-1:0]  arr_wr_tag;
  logic [LINE_W-1:0] arr_wr_line;

  vipt_tlb #(
    .ENTRIES(TLB_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_tlb (
    .clk(clk), .rst_n(rst_n_i),
    .lk_asid(lk_asid), .lk_vpn(lk_vaddr[VA_W-1:PAGE_OFF_W]),
    .lk_hit(tlb_hit), .lk_ppn(tlb_ppn),
    .fill_en(tlb_fill_valid), .fill_asid(tlb_fill_asid),
    .fill_vpn(tlb_fill_vpn), .fill_ppn(tlb_fill_ppn)
  );

  vipt_array #(
    .SETS(SETS), .PPN_W(PPN_W), .LINE_W(LINE_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n_i),
    .rd_idx(lk_vaddr[LINE_OFF_W +: IDX_W]),
    .rd_valid(arr_valid), .rd_tag(arr_tag), .rd_line(arr_line),
    .wr_en(arr_wr_en), .wr_idx(arr_wr_idx), .wr_tag(arr_wr_tag), .wr_line(arr_wr_line)
  );

  vipt_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_OFF_W(PAGE_OFF_W), .LINE_OFF_W(LINE_OFF_W),
    .SETS(SETS), .ASID_W(ASID_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_fill_valid(tlb_fill_valid),
    .arr_valid(arr_valid), .arr_tag(arr_tag), .arr_line(arr_line),
    .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx), .arr_wr_tag(arr_wr_tag),
    .arr_wr_line(arr_wr_line),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .busy(busy), .xlat_miss(xlat_miss),
    .miss_req_valid(miss_req_valid), .miss_req_paddr(miss_req_paddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_tlb_miss(resp_tlb_miss), .resp_data(resp_data)
  );
endmodule

// File: tb/tb_vipt_cache.sv
module tb_vipt_cache;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic [7:0]   req_asid;
  logic         busy;
  logic         tlb_fill_valid;
  logic [7:0]   tlb_fill_asid;
  logic [19:0]  tlb_fill_vpn;
  logic [19:0]  tlb_fill_ppn;
  logic         xlat_miss;
  logic         miss_req_valid;
  logic [31:0]  miss_req_paddr;
  logic         fill_valid;
  logic [127:0] fill_data;
  logic         resp_valid;
  logic         resp_hit;
  logic         resp_miss;
  logic         resp_tlb_miss;
  logic [31:0]  resp_data;

  vipt_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid), .busy(busy),
    .tlb_fill_valid(tlb_fill_valid), .tlb_fill_asid(tlb_fill_asid),
    .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
    .xlat_miss(xlat_miss), .miss_req_valid(miss_req_valid), .miss_req_paddr(miss_req_paddr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_tlb_miss(resp_tlb_miss), .resp_data(resp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model of translation store and array state
  bit          mv   [8];
  logic [7:0]  ma   [8];
  logic [19:0] mvpn [8];
  logic [19:0] mppn [8];
  int          mptr;
  bit          cv   [256];
  logic [19:0] ctag [256];
  bit          last_hit;
  bit          last_tlbm;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [19:0] map_ppn(input logic [7:0] as, input logic [19:0] vpn);
    logic [19:0] s;
    s = vpn + ({12'h0, as} << 2);
    return 20'h00400 + (s & 20'h0000F);
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] pl, input int w);
    return pl ^ (32'h1357_9BDF * 32'(w + 1));
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] pl);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of(pl, w);
    return l;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) mv[i] = 1'b0;
    for (int i = 0; i < 256; i++) cv[i] = 1'b0;
    mptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    tlb_fill_valid = 1'b0;
    fill_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !xlat_miss && !miss_req_valid && !resp_valid, "R10 in reset",
        {28'h0, busy, xlat_miss, miss_req_valid, resp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !xlat_miss && !miss_req_valid && !resp_valid, "R10 after reset",
        {28'h0, busy, xlat_miss, miss_req_valid, resp_valid}, 32'h0);
    model_clear();
  endtask

  task automatic access(input logic [31:0] va, input logic [7:0] as);
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [7:0]  idx;
    logic [31:0] pl;
    int          w;
    bit          th;
    vpn = va[31:12];
    idx = va[11:4];
    w   = int'(va[3:2]);
    th  = 1'b0;
    ppn = '0;
    for (int i = 0; i < 8; i++) begin
      if (mv[i] && ma[i] == as && mvpn[i] == vpn) begin
        th  = 1'b1;
        ppn = mppn[i];
      end
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_asid  = as;
    @(negedge clk);
    req_valid = 1'b0;
    if (!th) begin
      chk(xlat_miss && busy && !resp_valid, "R3 stall on translation miss",
          {29'h0, xlat_miss, busy, resp_valid}, 32'h6);
      if ($urandom % 2 == 1) begin
        req_valid = 1'b1;
        req_vaddr = $urandom;
        @(negedge clk);
        req_valid = 1'b0;
        chk(xlat_miss && !resp_valid, "R9 request ignored in translation wait",
            {30'h0, xlat_miss, resp_valid}, 32'h2);
      end
      ppn = map_ppn(as, vpn);
      tlb_fill_valid = 1'b1;
      tlb_fill_asid  = as;
      tlb_fill_vpn   = vpn;
      tlb_fill_ppn   = ppn;
      mv[mptr] = 1'b1; ma[mptr] = as; mvpn[mptr] = vpn; mppn[mptr] = ppn;
      mptr = (mptr + 1) % 8;
      @(negedge clk);
      tlb_fill_valid = 1'b0;
      @(negedge clk);
    end
    pl = {ppn, idx, 4'h0};
    if (cv[idx] && ctag[idx] == ppn) begin
      chk(resp_valid && resp_hit && !resp_miss, "R2 hit response",
          {29'h0, resp_valid, resp_hit, resp_miss}, 32'h6);
      chk(resp_data == word_of(pl, w), "R1 hit data via physical tag", resp_data, word_of(pl, w));
      chk(resp_tlb_miss == !th, "R3 translation flag", {31'h0, resp_tlb_miss}, {31'h0, !th});
      last_hit = 1'b1;
    end else begin
      chk(miss_req_valid && !resp_valid, "R6 miss request raised",
          {30'h0, miss_req_valid, resp_valid}, 32'h2);
      chk(miss_req_paddr == pl, "R6 miss address", miss_req_paddr, pl);
      repeat ($urandom % 3) begin
        req_valid = 1'($urandom % 2);
        req_vaddr = $urandom;
        @(negedge clk);
        req_valid = 1'b0;
        chk(miss_req_valid && !resp_valid && miss_req_paddr == pl, "R9 miss wait held",
            miss_req_paddr, pl);
      end
      fill_valid = 1'b1;
      fill_data  = line_of(pl);
      @(negedge clk);
      fill_valid = 1'b0;
      chk(resp_valid && resp_miss && !resp_hit, "R7 fill response",
          {29'h0, resp_valid, resp_hit, resp_miss}, 32'h5);
      chk(resp_data == word_of(pl, w), "R7 fill data", resp_data, word_of(pl, w));
      chk(resp_tlb_miss == !th, "R3 translation flag", {31'h0, resp_tlb_miss}, {31'h0, !th});
      cv[idx] = 1'b1;
      ctag[idx] = ppn;
      last_hit = 1'b0;
    end
    last_tlbm = !th;
    chk(!busy, "R9 idle after response", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    req_valid = 1'b0; req_vaddr = '0; req_asid = '0;
    tlb_fill_valid = 1'b0; tlb_fill_asid = '0; tlb_fill_vpn = '0; tlb_fill_ppn = '0;
    fill_valid = 1'b0; fill_data = '0;
    last_hit = 1'b0; last_tlbm = 1'b0;
    model_clear();
    do_reset();

    // first access: translation miss then line miss (R10)
    access(32'h0000_1234, 8'd1);
    chk(last_tlbm && !last_hit, "R10 cold start misses", {30'h0, last_tlbm, last_hit}, 32'h2);
    access(32'h0000_1234, 8'd1);
    chk(last_hit && !last_tlbm, "R2 repeat hits", {30'h0, last_tlbm, last_hit}, 32'h1);
    access(32'h0000_1238, 8'd1);
    chk(last_hit, "R2 other word same line", {31'h0, last_hit}, 32'h1);

    // context switch: another space maps a different page onto the same frame (R5, R1)
    access(32'h0000_D234, 8'd2);
    chk(last_hit && last_tlbm, "R5 synonym hit across spaces", {30'h0, last_tlbm, last_hit}, 32'h3);
    access(32'h0000_1234, 8'd1);
    chk(last_hit, "R5 original space still hits", {31'h0, last_hit}, 32'h1);

    // same page number, other space: no translation match (R4)
    access(32'h0000_1234, 8'd3);
    chk(last_tlbm, "R4 space mismatch misses translation", {31'h0, last_tlbm}, 32'h1);

    // round-robin eviction (R8)
    for (int k = 0; k < 9; k++) access({12'h0, 8'h20 + 8'(k), 12'h040}, 8'd5);
    access(32'h0002_0040, 8'd5);
    chk(last_tlbm, "R8 oldest entry evicted", {31'h0, last_tlbm}, 32'h1);
    access(32'h0002_8040, 8'd5);
    chk(!last_tlbm, "R8 newest entry kept", {31'h0, last_tlbm}, 32'h0);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] va;
      va = {12'h0, 8'($urandom % 12), 12'($urandom)};
      access(va, 8'($urandom % 4));
    end

    // reset clears all valid state (R10)
    do_reset();
    access(32'h0000_1234, 8'd1);
    chk(last_tlbm && !last_hit, "R10 state cleared by reset", {30'h0, last_tlbm, last_hit}, 32'h2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule